// File: doc/BRIEF.md
# Segment Base-and-Bound Address Translator

This block maps a 32-bit virtual address onto a 30-bit physical address, which covers up to 1 GB of memory. The three most significant address bits select one of eight segment descriptors. The remaining 29 bits are an offset inside that segment. Each descriptor holds a physical base, a limit (bound), a present flag and a write-lock flag. A translation adds the offset to the base of the selected segment. Before doing so, it checks that the offset lies below the limit, that the sum stays inside the 30-bit physical space, and that a write does not target a write-locked segment, such as a shared code segment.

Software loads descriptors through a plain one-cycle write port.

Requests and responses flow on two valid/ready channels, and a translation takes one cycle:
- A request is taken on any clock edge where both `req_valid` and `req_ready` are high.
- Its result appears on the response channel in the next cycle.
- The result stays there, unchanged, until `rsp_ready` is seen high.
- `req_ready` is high whenever the response register is empty, or is being drained in the same cycle. A stalled consumer therefore stalls the producer without losing or duplicating a result.

Top module: `seg_xlat`

## Requirements
- R1: After reset, `rsp_valid` is low, `req_ready` is high, and every descriptor is marked not present.
- R2: Bits 31..29 of `req_vaddr` select the descriptor. Bits 28..0 form the offset.
- R3: A request with no fault returns `rsp_fault` = 0 and `rsp_paddr` = base + offset.
- R4: A request to a descriptor whose present flag is clear returns `rsp_fault` = 1.
- R5: A request whose offset is greater than or equal to the descriptor's limit returns `rsp_fault` = 2. An offset of limit-1 is accepted.
- R6: A request where base + offset does not fit in 30 bits returns `rsp_fault` = 2.
- R7: A write (`req_write` = 1) to a write-locked descriptor returns `rsp_fault` = 3. A read of the same descriptor translates normally.
- R8: When more than one fault applies, code 1 beats code 2, and code 2 beats code 3.
- R9: A request accepted on an edge gives `rsp_valid` high after that edge, carrying its result. With no acceptance and the response drained (or none pending), `rsp_valid` is low after the edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_paddr` and `rsp_fault` hold their values.
- R11: A descriptor write on an edge affects only requests accepted on later edges. A request accepted on the same edge uses the old contents.
- R12: A faulting response drives `rsp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor write strobe |
| cfg_idx | input | 3 | Descriptor to write |
| cfg_base | input | 30 | Physical base to store |
| cfg_bound | input | 30 | Limit to store (offsets below it are legal) |
| cfg_present | input | 1 | Present flag to store |
| cfg_wlock | input | 1 | Write-lock flag to store |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_paddr | output | 30 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 not present, 2 limit/overflow, 3 write-locked |

## Verification
Several input patterns exercise the translation:
- Reads and writes to ordinary segments.
- Offsets placed at limit-1 and at the limit, which separate the `>` and `>=` forms of the limit test.
- A base near the top of physical space, which exposes a carry lost at 30 bits.
- Overlapping fault conditions on one descriptor, which tell the priority order apart.

A request issued on the same edge as a descriptor write separates old-contents from new-contents behaviour. Stretches with the consumer stalled show whether results are held or dropped. A long random mix of requests, stalls and descriptor writes is then compared on every clock against a behavioural model.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_ABSENT  = 2'd1,
    FLT_LIMIT   = 2'd2,
    FLT_WLOCK   = 2'd3
  } fault_e;

endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table #(
  parameter int NSEG  = 8,
  parameter int PA_W  = 30,
  parameter int LIM_W = 30,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PA_W-1:0]  wr_base,
  input  logic [LIM_W-1:0] wr_limit,
  input  logic             wr_present,
  input  logic             wr_wlock,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic             rd_present,
  output logic             rd_wlock
);

  logic [PA_W-1:0]  base_q    [NSEG];
  logic [LIM_W-1:0] limit_q   [NSEG];
  logic [NSEG-1:0]  present_q;
  logic [NSEG-1:0]  wlock_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        wlock_q[g]   <= 1'b0;
      end else if (hit) begin
        base_q[g]    <= wr_base;
        limit_q[g]   <= wr_limit;
        present_q[g] <= wr_present;
        wlock_q[g]   <= wr_wlock;
      end
    end
  end

  assign rd_base    = base_q[rd_idx];
  assign rd_limit   = limit_q[rd_idx];
  assign rd_present = present_q[rd_idx];
  assign rd_wlock   = wlock_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int PA_W  = 30,
  parameter int OFF_W = 29,
  parameter int LIM_W = 30,
  localparam int SUM_W = ((PA_W > OFF_W) ? PA_W : OFF_W) + 1
) (
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic             present,
  input  logic             wlock,
  output logic [PA_W-1:0]  paddr,
  output fault_e           fault
);

  logic [SUM_W-1:0] sum;
  logic             carry_out;
  logic             over_limit;

  assign sum        = SUM_W'(base) + SUM_W'(offset);
  assign carry_out  = |sum[SUM_W-1:PA_W];
  assign over_limit = (LIM_W'(offset) >= limit);

  always_comb begin
    fault = FLT_NONE;
    paddr = '0;
    if (!present) begin
      fault = FLT_ABSENT;
    end else if (over_limit || carry_out) begin
      fault = FLT_LIMIT;
    end else if (is_write && wlock) begin
      fault = FLT_WLOCK;
    end else begin
      paddr = sum[PA_W-1:0];
    end
  end

endmodule

// File: rtl/seg_rsp_stage.sv
module seg_rsp_stage
  import seg_xlat_pkg::*;
#(
  parameter int PA_W = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [PA_W-1:0] in_paddr,
  input  fault_e          in_fault,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [PA_W-1:0] out_paddr,
  output fault_e          out_fault
);

  logic            full_q;
  logic [PA_W-1:0] paddr_q;
  fault_e          fault_q;
  logic            take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q  <= 1'b0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
    end else begin
      if (take) begin
        full_q  <= 1'b1;
        paddr_q <= in_paddr;
        fault_q <= in_fault;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign out_valid = full_q;
  assign out_paddr = paddr_q;
  assign out_fault = fault_q;

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
  import seg_xlat_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PA_W     = 30,
  parameter int SEG_BITS = 3,
  localparam int OFF_W   = VA_W - SEG_BITS,
  localparam int NSEG    = 1 << SEG_BITS,
  localparam int LIM_W   = OFF_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_idx,
  input  logic [PA_W-1:0]     cfg_base,
  input  logic [LIM_W-1:0]    cfg_bound,
  input  logic                cfg_present,
  input  logic                cfg_wlock,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                req_write,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic [1:0]          rsp_fault
);

  logic [SEG_BITS-1:0] seg_sel;
  logic [OFF_W-1:0]    seg_off;
  logic [PA_W-1:0]     d_base;
  logic [LIM_W-1:0]    d_limit;
  logic                d_present;
  logic                d_wlock;
  logic [PA_W-1:0]     x_paddr;
  fault_e              x_fault;
  fault_e              r_fault;

  assign seg_sel = req_vaddr[VA_W-1 -: SEG_BITS];
  assign seg_off = req_vaddr[OFF_W-1:0];

  seg_desc_table #(
    .NSEG (NSEG),
    .PA_W (PA_W),
    .LIM_W(LIM_W)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_idx),
    .wr_base   (cfg_base),
    .wr_limit  (cfg_bound),
    .wr_present(cfg_present),
    .wr_wlock  (cfg_wlock),
    .rd_idx    (seg_sel),
    .rd_base   (d_base),
    .rd_limit  (d_limit),
    .rd_present(d_present),
    .rd_wlock  (d_wlock)
  );

  seg_check #(
    .PA_W (PA_W),
    .OFF_W(OFF_W),
    .LIM_W(LIM_W)
  ) i_check (
    .offset  (seg_off),
    .is_write(req_write),
    .base    (d_base),
    .limit   (d_limit),
    .present (d_present),
    .wlock   (d_wlock),
    .paddr   (x_paddr),
    .fault   (x_fault)
  );

  seg_rsp_stage #(
    .PA_W(PA_W)
  ) i_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (req_valid),
    .in_ready (req_ready),
    .in_paddr (x_paddr),
    .in_fault (x_fault),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_paddr(rsp_paddr),
    .out_fault(r_fault)
  );

  assign rsp_fault = r_fault;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_fault
);

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R10

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid && req_ready) && !(rsp_valid && !rsp_ready)) |=> !rsp_valid); // R9

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault != 2'd0)) |-> (rsp_paddr == '0)); // R12

  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready); // R1

endmodule

bind seg_xlat seg_xlat_chk #(.PA_W(PA_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault)
);

// File: tb/test_seg_xlat.sv
module test_seg_xlat;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [29:0] cfg_base = '0;
  logic [29:0] cfg_bound = '0;
  logic        cfg_present = 1'b0;
  logic        cfg_wlock = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [29:0] rsp_paddr;
  logic [1:0]  rsp_fault;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // behavioural reference state
  longint m_base [8];
  longint m_lim  [8];
  bit     m_pres [8];
  bit     m_lock [8];
  bit     exp_v = 0;
  longint exp_pa = 0;
  int     exp_f = 0;

  always #10 clk = ~clk;  // 50 MHz

  seg_xlat i_seg_xlat (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string tag, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, expv);
    end
  endtask

  task automatic model(input longint va, input bit wr, output longint pa, output int f);
    int     idx;
    longint off;
    idx = int'((va >> 29) & 7);
    off = va & 64'h1FFF_FFFF;
    pa = 0;
    if (!m_pres[idx]) f = 1;
    else if (off >= m_lim[idx] || m_base[idx] + off >= 64'h4000_0000) f = 2;
    else if (wr && m_lock[idx]) f = 3;
    else begin
      f = 0;
      pa = m_base[idx] + off;
    end
  endtask

  // one clock: inputs already set just after a falling edge
  task automatic tick(string tag);
    bit     acc;
    longint npa;
    int     nf;
    #1;
    chk(tag, "req_ready", longint'(req_ready), longint'(!exp_v || rsp_ready));
    acc = req_valid && (!exp_v || rsp_ready);
    npa = 0;
    nf = 0;
    if (acc) model(longint'(req_vaddr), req_write, npa, nf);
    @(posedge clk);
    if (acc) begin
      exp_v = 1;
      exp_pa = npa;
      exp_f = nf;
    end else if (exp_v && rsp_ready) begin
      exp_v = 0;
    end
    if (cfg_we) begin
      m_base[cfg_idx] = longint'(cfg_base);
      m_lim[cfg_idx]  = longint'(cfg_bound);
      m_pres[cfg_idx] = cfg_present;
      m_lock[cfg_idx] = cfg_wlock;
    end
    @(negedge clk);
    chk(tag, "rsp_valid", longint'(rsp_valid), longint'(exp_v));
    if (exp_v) begin
      chk(tag, "rsp_fault", longint'(rsp_fault), longint'(exp_f));
      chk(tag, "rsp_paddr", longint'(rsp_paddr), exp_pa);
    end
  endtask

  task automatic wr_desc(int idx, longint base, longint lim, bit pres, bit lock);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = 30'(base);
    cfg_bound = 30'(lim); cfg_present = pres; cfg_wlock = lock;
    req_valid = 0;
    tick("R11");
    cfg_we = 0;
  endtask

  task automatic req(string tag, int seg, longint off, bit wr);
    req_valid = 1; req_write = wr;
    req_vaddr = {3'(seg), 29'(off)};
    tick(tag);
    req_valid = 0;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_base[i] = 0; m_lim[i] = 0; m_pres[i] = 0; m_lock[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", "rsp_valid after reset", longint'(rsp_valid), 0);
    chk("R1", "req_ready after reset", longint'(req_ready), 1);
    req("R1", 0, 0, 0);   // all absent -> code 1
    req("R4", 5, 10, 1);
    tick("R9");           // drained, no new request

    wr_desc(1, 64'h1000_0000, 64'h1000, 1, 0);
    wr_desc(2, 64'h0000_4000, 64'h800, 1, 1);
    wr_desc(3, 64'h3FFF_F000, 64'h2000, 1, 0);
    wr_desc(7, 64'h0, 64'h2000_0000, 1, 0);
    wr_desc(6, 64'h100, 64'h0, 0, 1);

    req("R3", 1, 64'h123, 0);
    req("R3", 1, 64'h456, 1);
    req("R2", 7, 64'h1ABC_DEF0, 0);
    req("R5", 1, 64'hFFF, 0);     // limit-1 ok
    req("R5", 1, 64'h1000, 0);    // at limit
    req("R6", 3, 64'hFFF, 0);     // last in-range byte
    req("R6", 3, 64'h1000, 0);    // carry past 30 bits
    req("R7", 2, 64'h10, 1);
    req("R7", 2, 64'h10, 0);
    req("R8", 2, 64'h900, 1);     // limit beats write-lock
    req("R8", 6, 64'h5, 1);       // absent beats limit and lock

    // R10: stall with a request pending
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_vaddr = {3'd1, 29'h20};
    tick("R10");
    req_vaddr = {3'd1, 29'h40};
    repeat (3) tick("R10");
    rsp_ready = 1;
    tick("R10");
    req_vaddr = {3'd2, 29'h8};
    tick("R10");
    req_valid = 0;
    tick("R9");

    // R11: write and request on the same edge
    cfg_we = 1; cfg_idx = 3'd4; cfg_base = 30'h200; cfg_bound = 30'h100;
    cfg_present = 1; cfg_wlock = 0;
    req_valid = 1; req_write = 0; req_vaddr = {3'd4, 29'h10};
    tick("R11");
    cfg_we = 0;
    tick("R11");
    req_valid = 0;
    tick("R11");

    // mixed traffic, R8 covers all fault orderings
    for (int n = 0; n < 2000; n++) begin
      req_valid = 1'($urandom_range(0, 3) != 0);
      rsp_ready = 1'($urandom_range(0, 3) != 0);
      req_write = 1'($urandom);
      req_vaddr = {3'($urandom), 29'($urandom_range(0, 32'h3000))};
      cfg_we = 1'($urandom_range(0, 15) == 0);
      cfg_idx = 3'($urandom);
      cfg_base = ($urandom_range(0, 1) == 0) ? 30'($urandom) : 30'h3FFF_E000;
      cfg_bound = 30'($urandom_range(0, 32'h3000));
      cfg_present = 1'($urandom_range(0, 3) != 0);
      cfg_wlock = 1'($urandom);
      tick("R8");
    end
    cfg_we = 0; req_valid = 0; rsp_ready = 1;
    tick("R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule